// File: doc/BRIEF.md
# Partially Triplicated Ripple-Carry Adder

This block adds two W-bit unsigned operands and a carry-in with a ripple-carry chain, in which the carry moves one position at a time from the least significant bit up. Only the top P result positions are protected. The low W−P positions form one plain chain. Its carry-out feeds three independent copies of the upper P-bit chain. A bitwise 2-of-3 majority vote resolves each upper sum bit and the final carry. A fault in a high-weight bit does far more numeric damage than one in a low-weight bit, so this buys most of the protection of a fully tripled adder at a small part of its area.

The block is purely combinational. For verification, each full adder's sum and carry output can be inverted on its own through fault-flip masks. There is one mask set for the lower chain and one per upper copy. In normal use all masks are tied to zero.

Top module: `ptmr_adder`

## Requirements
- R1: With every flip mask at zero, `sum` equals (op_a + op_b + carry_in) mod 2^W.
- R2: With every flip mask at zero, `carry_out` equals bit W of op_a + op_b + carry_in.
- R3: Any set of flips confined to one upper copy leaves `sum` and `carry_out` equal to the fault-free result, with the lower masks at zero. Upper copy k uses mask bits [k*P + j], where j is the position counted from bit W−P.
- R4: When two upper copies flip the sum output at the same position j, result bit W−P+j is inverted and all other result bits are correct.
- R5: When two upper copies flip the carry output at the same position j, the result equals the true sum with the carry into position W−P+j+1 inverted. For j = P−1 this inverts only `carry_out`.
- R6: Setting bit i of `flip_lo_sum` (i < W−P) inverts exactly result bit i.
- R7: Setting bit i of `flip_lo_cry` (i < W−P) makes the result equal to the true sum with the carry into position i+1 inverted. This corruption spreads into the upper bits, because all three copies share that carry.
- R8: The block works for W from 16 to 32 with P = 3 or P = 4. A P outside 1..W halts elaboration.
- R9: Carries ripple through the full width, including through the boundary between the lower chain and the upper copies. For example, all-ones plus zero with carry_in = 1 gives sum 0 and carry_out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| flip_lo_sum | input | max(W−P,1) | Inverts the sum output of a lower full adder |
| flip_lo_cry | input | max(W−P,1) | Inverts the carry output of a lower full adder |
| flip_hi_sum | input | 3*P | Inverts sum outputs of the upper copies, copy k in bits [k*P +: P] |
| flip_hi_cry | input | 3*P | Inverts carry outputs of the upper copies, same layout |
| sum | output | W | Result, upper P bits voted |
| carry_out | output | 1 | Voted carry-out |

## Verification
The bench builds two instances side by side: W=16 with P=4, and W=32 with P=3. This exercises both legal protected widths, the narrow and wide ends of the operand range, and two different splits between the lower and upper sections. Both instances are driven with the same fault descriptors. A lower carry flip, a single-copy flip and a two-copy flip therefore land at different global positions in each instance, which checks the index mapping of the fault masks as well as the voting. Random operands mixed with all-ones and boundary patterns push carries through the lower-to-upper boundary in both widths.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int unsigned COPIES = 3;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (x & z);
    endfunction

endpackage

// File: rtl/ptmr_rca_chain.sv
module ptmr_rca_chain #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         c_in,
    input  logic [N-1:0] inv_sum,
    input  logic [N-1:0] inv_cry,
    output logic [N-1:0] sum_o,
    output logic         c_out
);
    import ptmr_pkg::*;

    logic [N:0] cry;

    assign cry[0] = c_in;

    for (genvar i = 0; i < N; i++) begin : g_fa
        assign sum_o[i]   = op_a[i] ^ op_b[i] ^ cry[i] ^ inv_sum[i];
        assign cry[i+1]   = maj3(op_a[i], op_b[i], cry[i]) ^ inv_cry[i];
    end

    assign c_out = cry[N];

    // Checks on the chain against plain arithmetic
    logic [N:0] exact_val;
    always_comb begin
        exact_val = {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, c_in};
        if (inv_sum == '0 && inv_cry == '0) begin
            a_r1_chain_exact: assert ({c_out, sum_o} == exact_val)
                else $error("chain result differs from arithmetic sum");
        end
        if (inv_cry == '0 && $countones(inv_sum) == 1) begin
            a_r6_single_sum_flip: assert ({1'b0, sum_o ^ exact_val[N-1:0]} == {1'b0, inv_sum})
                else $error("single sum flip did not hit exactly its bit");
        end
    end

endmodule

// File: rtl/ptmr_maj_voter.sv
module ptmr_maj_voter #(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] in_0,
    input  logic [N-1:0] in_1,
    input  logic [N-1:0] in_2,
    output logic [N-1:0] voted
);
    import ptmr_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign voted[i] = maj3(in_0[i], in_1[i], in_2[i]);
    end

    always_comb begin
        if (in_0 == in_1) begin
            a_r3_pair01_wins: assert (voted == in_0)
                else $error("voter ignored agreeing copies 0 and 1");
        end
        if (in_1 == in_2) begin
            a_r3_pair12_wins: assert (voted == in_1)
                else $error("voter ignored agreeing copies 1 and 2");
        end
        if (in_0 == in_2) begin
            a_r3_pair02_wins: assert (voted == in_2)
                else $error("voter ignored agreeing copies 0 and 2");
        end
    end

endmodule

// File: rtl/ptmr_adder.sv
module ptmr_adder #(
    parameter int unsigned W = 16,
    parameter int unsigned P = 4
) (
    input  logic [W-1:0]                          op_a,
    input  logic [W-1:0]                          op_b,
    input  logic                                  carry_in,
    input  logic [((W > P) ? (W - P) : 1)-1:0]    flip_lo_sum,
    input  logic [((W > P) ? (W - P) : 1)-1:0]    flip_lo_cry,
    input  logic [3*P-1:0]                        flip_hi_sum,
    input  logic [3*P-1:0]                        flip_hi_cry,
    output logic [W-1:0]                          sum,
    output logic                                  carry_out
);
    import ptmr_pkg::*;

    localparam int unsigned LO_W = (W > P) ? (W - P) : 0;

    // R8: parameter legality
    if (P < 1 || P > W) begin : g_bad_param
        $error("ptmr_adder: P must lie in 1..W");
    end

    logic         lo_cout;
    logic [P-1:0] cp_sum [COPIES];
    logic         cp_co  [COPIES];
    logic [P:0]   hi_voted;

    if (LO_W > 0) begin : g_lo
        logic [LO_W-1:0] lo_sum;
        ptmr_rca_chain #(.N(LO_W)) i_lo_chain (
            .op_a   (op_a[LO_W-1:0]),
            .op_b   (op_b[LO_W-1:0]),
            .c_in   (carry_in),
            .inv_sum(flip_lo_sum),
            .inv_cry(flip_lo_cry),
            .sum_o  (lo_sum),
            .c_out  (lo_cout)
        );
        assign sum = {hi_voted[P-1:0], lo_sum};
    end else begin : g_no_lo
        assign lo_cout = carry_in;
        assign sum     = hi_voted[P-1:0];
    end

    for (genvar k = 0; k < COPIES; k++) begin : g_copy
        ptmr_rca_chain #(.N(P)) i_hi_chain (
            .op_a   (op_a[W-1:LO_W]),
            .op_b   (op_b[W-1:LO_W]),
            .c_in   (lo_cout),
            .inv_sum(flip_hi_sum[k*P +: P]),
            .inv_cry(flip_hi_cry[k*P +: P]),
            .sum_o  (cp_sum[k]),
            .c_out  (cp_co[k])
        );
    end

    ptmr_maj_voter #(.N(P + 1)) i_voter (
        .in_0 ({cp_co[0], cp_sum[0]}),
        .in_1 ({cp_co[1], cp_sum[1]}),
        .in_2 ({cp_co[2], cp_sum[2]}),
        .voted(hi_voted)
    );

    assign carry_out = hi_voted[P];

    // Block-level checks
    logic [W:0] true_sum;
    int         dirty_copies;
    always_comb begin
        true_sum     = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
        dirty_copies = 0;
        for (int k = 0; k < COPIES; k++) begin
            if (flip_hi_sum[k*P +: P] != '0 || flip_hi_cry[k*P +: P] != '0)
                dirty_copies++;
        end
        if (flip_lo_sum == '0 && flip_lo_cry == '0 && dirty_copies == 0) begin
            a_r1_clean_sum: assert (sum == true_sum[W-1:0])
                else $error("fault-free sum wrong");
            a_r2_clean_carry: assert (carry_out == true_sum[W])
                else $error("fault-free carry-out wrong");
        end
        if (flip_lo_sum == '0 && flip_lo_cry == '0 && dirty_copies == 1) begin
            a_r3_single_copy_masked: assert ({carry_out, sum} == true_sum)
                else $error("single upper copy fault leaked to output");
        end
    end

endmodule

// File: tb/test_ptmr_adder.sv
module test_ptmr_adder;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Instance A: W=16, P=4
    logic [15:0] a16, b16, s16;
    logic [11:0] fls16, flc16;
    logic [11:0] fhs16, fhc16;
    logic        co16;
    // Instance B: W=32, P=3
    logic [31:0] a32, b32, s32;
    logic [28:0] fls32, flc32;
    logic [8:0]  fhs32, fhc32;
    logic        co32;
    logic        cin;

    ptmr_adder #(.W(16), .P(4)) i_ptmr_adder (
        .op_a(a16), .op_b(b16), .carry_in(cin),
        .flip_lo_sum(fls16), .flip_lo_cry(flc16),
        .flip_hi_sum(fhs16), .flip_hi_cry(fhc16),
        .sum(s16), .carry_out(co16)
    );

    ptmr_adder #(.W(32), .P(3)) i_ptmr_adder_w32 (
        .op_a(a32), .op_b(b32), .carry_in(cin),
        .flip_lo_sum(fls32), .flip_lo_cry(flc32),
        .flip_hi_sum(fhs32), .flip_hi_cry(fhc32),
        .sum(s32), .carry_out(co32)
    );

    // Expected {carry_out, sum}: optional single carry inversion at position cpos
    // (carry into cpos+1 flipped), then sum-bit inversion mask.
    function automatic longint unsigned expect_val(
        input longint unsigned a, input longint unsigned b, input bit ci,
        input int w, input int cpos, input longint unsigned smask);
        longint unsigned full, m, low, high, c;
        int l;
        if (cpos < 0) begin
            full = a + b + ci;
        end else begin
            l    = cpos + 1;
            m    = (64'd1 << l) - 1;
            low  = (a & m) + (b & m) + ci;
            c    = (low >> l) & 1;
            high = (a >> l) + (b >> l) + (c ^ 1);
            full = (high << l) | (low & m);
        end
        full = full ^ smask;
        return full & ((64'd1 << (w + 1)) - 1);
    endfunction

    task automatic check(input string tag, input string inst,
                         input longint unsigned got, input longint unsigned exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%h expected=%h", tag, inst, got, exp);
        end
    endtask

    // ls/lc: lower sum/carry flip bit (-1 none); hs_j/hc_j: upper position (-1 none)
    // hs_cp/hc_cp: which upper copies receive that flip.
    task automatic run(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input bit ci, input int ls, input int lc,
                       input int hs_j, input bit [2:0] hs_cp,
                       input int hc_j, input bit [2:0] hc_cp);
        longint unsigned sm16, sm32;
        int cp16, cp32;
        @(negedge clk);
        a16 = a[15:0]; b16 = b[15:0]; a32 = a; b32 = b; cin = ci;
        fls16 = '0; flc16 = '0; fhs16 = '0; fhc16 = '0;
        fls32 = '0; flc32 = '0; fhs32 = '0; fhc32 = '0;
        sm16 = 0; sm32 = 0; cp16 = -1; cp32 = -1;
        if (ls >= 0) begin
            fls16[ls] = 1'b1; fls32[ls] = 1'b1;
            sm16 = 64'd1 << ls; sm32 = 64'd1 << ls;
        end
        if (lc >= 0) begin
            flc16[lc] = 1'b1; flc32[lc] = 1'b1;
            cp16 = lc; cp32 = lc;
        end
        for (int k = 0; k < 3; k++) begin
            if (hs_j >= 0 && hs_cp[k]) begin
                fhs16[k*4 + hs_j] = 1'b1; fhs32[k*3 + hs_j] = 1'b1;
            end
            if (hc_j >= 0 && hc_cp[k]) begin
                fhc16[k*4 + hc_j] = 1'b1; fhc32[k*3 + hc_j] = 1'b1;
            end
        end
        if (hs_j >= 0 && $countones(hs_cp) >= 2) begin
            sm16 |= 64'd1 << (12 + hs_j);
            sm32 |= 64'd1 << (29 + hs_j);
        end
        if (hc_j >= 0 && $countones(hc_cp) >= 2) begin
            cp16 = 12 + hc_j; cp32 = 29 + hc_j;
        end
        @(posedge clk);
        #2;
        check(tag, "W16P4", {47'd0, co16, s16}, expect_val(a[15:0], b[15:0], ci, 16, cp16, sm16));
        check(tag, "W32P3", {31'd0, co32, s32}, expect_val(a, b, ci, 32, cp32, sm32));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20150524));
        // Idle state: all-zero inputs give zero (R1, R2)
        run("R1_R2_zero", 32'h0, 32'h0, 1'b0, -1, -1, -1, 3'b000, -1, 3'b000);
        // Full ripple across the lower/upper boundary (R9)
        run("R9_ones_plus_cin", 32'hFFFF_FFFF, 32'h0, 1'b1, -1, -1, -1, 3'b000, -1, 3'b000);
        run("R9_ones_plus_ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, -1, -1, -1, 3'b000, -1, 3'b000);
        run("R2_top_carry", 32'h8000_8000, 32'h8000_8000, 1'b0, -1, -1, -1, 3'b000, -1, 3'b000);
        // Lower sum flips hit one bit only (R6)
        run("R6_lo_sum_b0", 32'h1234_5678, 32'h0F0F_0F0F, 1'b0, 0, -1, -1, 3'b000, -1, 3'b000);
        run("R6_lo_sum_b11", 32'hFFFF_FFFF, 32'h0, 1'b1, 11, -1, -1, 3'b000, -1, 3'b000);
        // Lower carry flips spread upward, including into the upper section (R7)
        run("R7_lo_cry_b3", 32'h0000_0005, 32'h0000_0003, 1'b0, -1, 3, -1, 3'b000, -1, 3'b000);
        run("R7_lo_cry_b11", 32'hFFFF_FFFF, 32'h0, 1'b1, -1, 11, -1, 3'b000, -1, 3'b000);
        // Two copies at same position defeat the vote (R4, R5)
        run("R4_two_sum", 32'hA5A5_A5A5, 32'h5A5A_1234, 1'b0, -1, -1, 1, 3'b011, -1, 3'b000);
        run("R4_three_sum", 32'h0, 32'h0, 1'b0, -1, -1, 2, 3'b111, -1, 3'b000);
        run("R5_two_cry_mid", 32'hFFFF_FFFF, 32'h0, 1'b1, -1, -1, -1, 3'b000, 0, 3'b101);
        run("R5_two_cry_top", 32'h0, 32'h0, 1'b0, -1, -1, -1, 3'b000, 2, 3'b110);
        // Every single-copy upper flip is masked (R3)
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 3; j++) begin
                run("R3_sweep_sum", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, -1, -1, j, 3'(1 << k), -1, 3'b000);
                run("R3_sweep_cry", 32'h7FFF_7FFF, 32'h0000_0001, 1'b1, -1, -1, -1, 3'b000, j, 3'(1 << k));
                run("R3_sweep_both", 32'h1357_9BDF, 32'h2468_ACE0, 1'b0, -1, -1, j, 3'(1 << k), 2 - j, 3'(1 << k));
            end
        end
        // Random clean and single-copy faulted traffic (R1, R2, R3, R8)
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra, rb;
            bit rc;
            int j, k, kind;
            ra = $urandom; rb = $urandom; rc = 1'($urandom);
            j = int'($urandom % 3); k = int'($urandom % 3); kind = int'($urandom % 3);
            if (kind == 0)
                run("R1_R2_R8_random", ra, rb, rc, -1, -1, -1, 3'b000, -1, 3'b000);
            else if (kind == 1)
                run("R3_R8_random_sum", ra, rb, rc, -1, -1, j, 3'(1 << k), -1, 3'b000);
            else
                run("R3_R8_random_cry", ra, rb, rc, -1, -1, -1, 3'b000, j, 3'(1 << k));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule